// File: doc/BRIEF.md
# Alternating Dual-Buffer PWM Generator

This block is a single-slope, single-output pulse-width timer. It holds two compare values and two period values. One of each pair is the active copy and the other is the secondary copy. An up-counter runs from zero to the active period and then wraps. The output is high while the count is below the active compare value.

Compare and period each have their own exchange enable. When a pair's exchange enable is set, its two copies trade places at every wrap. Two waveforms, each with its own frequency and duty, then alternate cycle by cycle on one pin. When a pair's exchange enable is clear, the secondary copy acts as an ordinary one-shot update buffer.

An overflow strobe marks the last count of every cycle. External logic can use it to write fresh secondary values.

Top module: `pwm_alt_gen`

## Requirements
- R1: While enabled, the counter steps by one per clock from 0 up to the active period value P, then returns to 0. Each output cycle therefore lasts P+1 clocks, so the output frequency is the clock rate divided by P+1.
- R2: `wave_out` is high exactly while the count is below the active compare value C. C = 0 gives a constant low output. C > P gives a constant high output. C = (P+1)/2 gives 50% duty.
- R3: `ovf` is high for exactly one clock per cycle: the clock in which the count equals the active period, whose closing edge wraps the counter.
- R4: With `circ_cmp_en` high, the active and secondary compare values trade places at every wrap.
- R5: With `circ_per_en` high, the active and secondary period values trade places at every wrap. This happens independently of the compare pair's mode.
- R6: With a pair's exchange enable low, a write to its secondary register is copied into the active register at the next wrap and then marked consumed. Later wraps copy nothing, and there is no swap back.
- R7: A secondary write in the same clock as a wrap does not affect that wrap. The exchange or copy uses the old secondary value, and the written value is held in the secondary register afterwards.
- R8: With `en` low, the counter is held at 0 and `wave_out` and `ovf` are low. Any pending exchange is undone, so re-enabling restarts from count 0 with the pair contents as they stood before any exchange.
- R9: A synchronous active-high `rst` clears the counter and all four value registers to zero. After reset with `en` low, the outputs are low. With `en` high and nothing written, `ovf` pulses every clock and `wave_out` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable |
| circ_cmp_en | input | 1 | Exchange mode for the compare pair |
| circ_per_en | input | 1 | Exchange mode for the period pair |
| cmp_pri_we | input | 1 | Write strobe, active compare |
| cmp_pri_wd | input | 24 | Data for the active compare |
| cmp_sec_we | input | 1 | Write strobe, secondary compare |
| cmp_sec_wd | input | 24 | Data for the secondary compare |
| per_pri_we | input | 1 | Write strobe, active period |
| per_pri_wd | input | 24 | Data for the active period |
| per_sec_we | input | 1 | Write strobe, secondary period |
| per_sec_wd | input | 24 | Data for the secondary period |
| ovf | output | 1 | High during the final count of each cycle |
| wave_out | output | 1 | PWM waveform |

## Verification
`wave_out` and `ovf` are combinational decodes of the registered count, so both respond in the same clock as the count they describe. Register writes and exchanges take effect from the first clock after the edge that captures them. The bench drives inputs just after a rising edge and samples on the falling edge. Each falling edge is therefore one whole counter state. The bench measures cycle length and high time by counting falling edges between `ovf` strobes.

// File: rtl/pwm_alt_pkg.sv
package pwm_alt_pkg;

    localparam int CNT_W = 24;

    // Update applied to a value pair at a clock edge
    typedef enum logic [1:0] {
        PA_HOLD,
        PA_SWAP,
        PA_LOAD,
        PA_RESTORE
    } pair_act_e;

    // Restore on disable takes precedence; a wrap then either exchanges or copies.
    function automatic pair_act_e pick_action(
        input logic run,
        input logic swapped,
        input logic wrap,
        input logic circ,
        input logic pend
    );
        if (!run && swapped)  return PA_RESTORE;
        if (wrap && circ)     return PA_SWAP;
        if (wrap && pend)     return PA_LOAD;
        return PA_HOLD;
    endfunction

endpackage

// File: rtl/pwm_alt_counter.sv
module pwm_alt_counter #(
    parameter int W = pwm_alt_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] per,
    output logic [W-1:0] cnt_q,
    output logic         wrap_o
);

    localparam logic [W-1:0] ONE = W'(1);

    // Greater-or-equal keeps the wrap safe if the period shrinks below the count
    assign wrap_o = en && (cnt_q >= per);

    always_ff @(posedge clk) begin
        if (rst || !en || wrap_o) cnt_q <= '0;
        else                      cnt_q <= cnt_q + ONE;
    end

    a_r1_count_step: assert property (@(posedge clk) disable iff (rst)
        (en && !wrap_o) |=> (cnt_q == $past(cnt_q) + ONE));

    a_r8_hold_zero: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cnt_q == '0));

endmodule

// File: rtl/pwm_alt_regpair.sv
module pwm_alt_regpair #(
    parameter int W = pwm_alt_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         circ,
    input  logic         wrap,
    input  logic         pri_we,
    input  logic [W-1:0] pri_wd,
    input  logic         sec_we,
    input  logic [W-1:0] sec_wd,
    output logic [W-1:0] act_q
);
    import pwm_alt_pkg::*;

    logic [W-1:0] sec_q, act_d, sec_d;
    logic         pend_q, pend_d;
    logic         swp_q, swp_d;
    pair_act_e    sel;

    always_comb begin
        sel    = pick_action(en, swp_q, wrap, circ, pend_q);
        act_d  = act_q;
        sec_d  = sec_q;
        pend_d = pend_q;
        swp_d  = swp_q;
        unique case (sel)
            PA_SWAP: begin
                act_d = sec_q;
                sec_d = act_q;
                swp_d = ~swp_q;
            end
            PA_RESTORE: begin
                act_d = sec_q;
                sec_d = act_q;
                swp_d = 1'b0;
            end
            PA_LOAD:  act_d = sec_q;
            default:  ;
        endcase
        if (wrap) pend_d = 1'b0;
        // Writes land after the wrap action, so a same-edge write is not used by it
        if (sec_we) begin
            sec_d  = sec_wd;
            pend_d = 1'b1;
        end
        if (pri_we) act_d = pri_wd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= '0;
            sec_q  <= '0;
            pend_q <= 1'b0;
            swp_q  <= 1'b0;
        end else begin
            act_q  <= act_d;
            sec_q  <= sec_d;
            pend_q <= pend_d;
            swp_q  <= swp_d;
        end
    end

    // R4 and R5: exchange at a wrap in circular mode
    a_r4_pair_exchange: assert property (@(posedge clk) disable iff (rst)
        (circ && wrap && !pri_we && !sec_we)
        |=> (act_q == $past(sec_q)) && (sec_q == $past(act_q)));

    a_r6_load_consume: assert property (@(posedge clk) disable iff (rst)
        (!circ && wrap && pend_q && !pri_we && !sec_we)
        |=> (act_q == $past(sec_q)) && !pend_q);

    a_r7_late_write_kept: assert property (@(posedge clk) disable iff (rst)
        (wrap && sec_we) |=> (sec_q == $past(sec_wd)) && pend_q);

    a_r8_restore: assert property (@(posedge clk) disable iff (rst)
        (!en && swp_q && !pri_we && !sec_we)
        |=> !swp_q && (act_q == $past(sec_q)));

endmodule

// File: rtl/pwm_alt_compare.sv
module pwm_alt_compare #(
    parameter int W = pwm_alt_pkg::CNT_W
) (
    input  logic         en,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cmp,
    output logic         wave
);
    assign wave = en && (cnt < cmp);
endmodule

// File: rtl/pwm_alt_gen.sv
module pwm_alt_gen #(
    parameter int W = pwm_alt_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         circ_cmp_en,
    input  logic         circ_per_en,
    input  logic         cmp_pri_we,
    input  logic [W-1:0] cmp_pri_wd,
    input  logic         cmp_sec_we,
    input  logic [W-1:0] cmp_sec_wd,
    input  logic         per_pri_we,
    input  logic [W-1:0] per_pri_wd,
    input  logic         per_sec_we,
    input  logic [W-1:0] per_sec_wd,
    output logic         ovf,
    output logic         wave_out
);

    logic [W-1:0] cnt, cmp_act, per_act;
    logic         wrap;

    pwm_alt_counter #(.W(W)) u_cnt (
        .clk(clk), .rst(rst), .en(en), .per(per_act),
        .cnt_q(cnt), .wrap_o(wrap)
    );

    pwm_alt_regpair #(.W(W)) u_cmp (
        .clk(clk), .rst(rst), .en(en), .circ(circ_cmp_en), .wrap(wrap),
        .pri_we(cmp_pri_we), .pri_wd(cmp_pri_wd),
        .sec_we(cmp_sec_we), .sec_wd(cmp_sec_wd),
        .act_q(cmp_act)
    );

    pwm_alt_regpair #(.W(W)) u_per (
        .clk(clk), .rst(rst), .en(en), .circ(circ_per_en), .wrap(wrap),
        .pri_we(per_pri_we), .pri_wd(per_pri_wd),
        .sec_we(per_sec_we), .sec_wd(per_sec_wd),
        .act_q(per_act)
    );

    pwm_alt_compare #(.W(W)) u_cmpo (
        .en(en), .cnt(cnt), .cmp(cmp_act), .wave(wave_out)
    );

    assign ovf = wrap;

    a_r2_zero_cmp_low: assert property (@(posedge clk) disable iff (rst)
        (cmp_act == '0) |-> !wave_out);

    a_r3_ovf_restarts: assert property (@(posedge clk) disable iff (rst)
        ovf |=> (cnt == '0));

    a_r8_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
        !en |-> (!wave_out && !ovf));

endmodule

// File: tb/tb_pwm_alt_gen.sv
`timescale 1ns/1ps
module tb_pwm_alt_gen;

    localparam int W = 24;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0, circ_cmp_en = 1'b0, circ_per_en = 1'b0;
    logic cmp_pri_we = 1'b0, cmp_sec_we = 1'b0, per_pri_we = 1'b0, per_sec_we = 1'b0;
    logic [W-1:0] cmp_pri_wd = '0, cmp_sec_wd = '0, per_pri_wd = '0, per_sec_wd = '0;
    logic ovf, wave_out;

    int n_chk = 0, n_bad = 0;
    int m_len [8];
    int m_high[8];

    always #2.5 clk = ~clk;

    pwm_alt_gen #(.W(W)) dut (
        .clk(clk), .rst(rst), .en(en),
        .circ_cmp_en(circ_cmp_en), .circ_per_en(circ_per_en),
        .cmp_pri_we(cmp_pri_we), .cmp_pri_wd(cmp_pri_wd),
        .cmp_sec_we(cmp_sec_we), .cmp_sec_wd(cmp_sec_wd),
        .per_pri_we(per_pri_we), .per_pri_wd(per_pri_wd),
        .per_sec_we(per_sec_we), .per_sec_wd(per_sec_wd),
        .ovf(ovf), .wave_out(wave_out)
    );

    // Columns: circ_cmp, circ_per, C_pri, P_pri, C_sec, P_sec, len0..len3, high0..high3
    localparam int NROW = 5;
    localparam int VEC [NROW][14] = '{
        '{1, 1, 2, 4, 5, 9,   5, 10, 5, 10,   2, 5, 2, 5},
        '{1, 0, 1, 5, 4, 7,   6, 8, 8, 8,     1, 4, 1, 4},
        '{0, 1, 3, 7, 6, 3,   8, 4, 8, 4,     3, 4, 6, 4},
        '{0, 0, 0, 3, 2, 6,   4, 7, 7, 7,     0, 2, 2, 2},
        '{1, 1, 9, 4, 0, 2,   5, 3, 5, 3,     5, 0, 5, 0}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst = 1'b1; en = 1'b0;
        @(posedge clk); #1;
        rst = 1'b0;
    endtask

    task automatic write_regs(input int ca, input int pa, input int cb, input int pb);
        @(posedge clk); #1;
        cmp_pri_we = 1'b1; cmp_pri_wd = W'(ca);
        per_pri_we = 1'b1; per_pri_wd = W'(pa);
        cmp_sec_we = 1'b1; cmp_sec_wd = W'(cb);
        per_sec_we = 1'b1; per_sec_wd = W'(pb);
        @(posedge clk); #1;
        cmp_pri_we = 1'b0; per_pri_we = 1'b0;
        cmp_sec_we = 1'b0; per_sec_we = 1'b0;
    endtask

    task automatic start_run();
        @(posedge clk); #1;
        en = 1'b1;
    endtask

    // Count falling edges per output cycle; optionally write the secondary compare
    // during the ovf clock of cycle 0 (same edge as the wrap).
    task automatic measure(input int n, input bit inj, input int inj_val);
        int len = 0, hi = 0, k = 0, guard = 0;
        bit armed = 1'b0;
        while (k < n && guard < 2000) begin
            @(negedge clk);
            guard++;
            if (armed) begin cmp_sec_we = 1'b0; armed = 1'b0; end
            len++;
            hi += int'(wave_out);
            if (ovf) begin
                m_len[k] = len; m_high[k] = hi;
                if (inj && k == 0) begin
                    cmp_sec_we = 1'b1; cmp_sec_wd = W'(inj_val); armed = 1'b1;
                end
                k++; len = 0; hi = 0;
            end
        end
        if (armed) begin @(posedge clk); #1; cmp_sec_we = 1'b0; end
        if (guard >= 2000) check(1'b0, "R3 ovf never seen", k, n);
    endtask

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R9: reset state
        do_reset();
        @(negedge clk);
        check(wave_out == 1'b0, "R9 wave after reset", int'(wave_out), 0);
        check(ovf == 1'b0, "R9 ovf after reset", int'(ovf), 0);
        start_run();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(ovf == 1'b1, "R9 zero period ovf", int'(ovf), 1);
            check(wave_out == 1'b0, "R9 zero compare wave", int'(wave_out), 0);
        end

        // Vector table: R1 R2 R4 R5 R6
        for (int r = 0; r < NROW; r++) begin
            do_reset();
            circ_cmp_en = VEC[r][0][0];
            circ_per_en = VEC[r][1][0];
            write_regs(VEC[r][2], VEC[r][3], VEC[r][4], VEC[r][5]);
            start_run();
            measure(4, 1'b0, 0);
            for (int k = 0; k < 4; k++) begin
                check(m_len[k] == VEC[r][6+k], "R1/R4/R5/R6 cycle length", m_len[k], VEC[r][6+k]);
                check(m_high[k] == VEC[r][10+k], "R2/R4/R5/R6 high time", m_high[k], VEC[r][10+k]);
            end
        end

        // R3: ovf only on the last count; R2 duty with C=2, P=3
        do_reset();
        circ_cmp_en = 1'b0; circ_per_en = 1'b0;
        write_regs(2, 3, 2, 3);
        start_run();
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check(ovf == ((i % 4) == 3), "R3 ovf position", int'(ovf), int'((i % 4) == 3));
            check(wave_out == ((i % 4) < 2), "R2 wave position", int'(wave_out), int'((i % 4) < 2));
        end

        // R7: secondary compare written on the wrap clock
        do_reset();
        circ_cmp_en = 1'b1; circ_per_en = 1'b1;
        write_regs(2, 7, 5, 7);
        start_run();
        measure(4, 1'b1, 7);
        check(m_high[0] == 2, "R7 high cycle 0", m_high[0], 2);
        check(m_high[1] == 5, "R7 old value used", m_high[1], 5);
        check(m_high[2] == 7, "R7 new value kept", m_high[2], 7);
        check(m_high[3] == 5, "R7 exchange continues", m_high[3], 5);

        // R8: disable while exchanged, then restart from primary set
        do_reset();
        circ_cmp_en = 1'b1; circ_per_en = 1'b1;
        write_regs(2, 4, 5, 9);
        start_run();
        measure(1, 1'b0, 0);
        @(posedge clk); #1;
        en = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(wave_out == 1'b0, "R8 wave off", int'(wave_out), 0);
            check(ovf == 1'b0, "R8 ovf off", int'(ovf), 0);
        end
        start_run();
        measure(2, 1'b0, 0);
        check(m_len[0] == 5, "R8 restart length", m_len[0], 5);
        check(m_high[0] == 2, "R8 restart high", m_high[0], 2);
        check(m_len[1] == 10, "R8 second length", m_len[1], 10);
        check(m_high[1] == 5, "R8 second high", m_high[1], 5);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule